// File: doc/BRIEF.md
# Aliased General Register File

This block stores 64 general-purpose registers, each 64 bits wide. A datapath reaches them in three ways. Two ports read a full entry by index. One port writes a full entry by index, and a narrow flag on that port turns the write into a sign-extending 32-bit store. A third read port gives a 32-bit compatibility view: the low word of the selected entry, zero-extended.

A set of named alias ports sits next to the indexed ports. They give older scalar state a fixed home inside the file. A 32-bit base pointer, a return address and a vector base each live in their own entry. A pair of accumulator halves shares one entry, and a one-bit condition flag shares another. Alias writes merge into their entry and change only the bits the alias owns. The highest-numbered entry is a constant zero.

Reads are combinational and writes take effect on the rising clock edge. There is no state machine. Every cycle applies the indexed write first and then overlays any alias writes. A synchronous reset clears every entry.

Top module: `gpr_alias_file`

## Requirements
- R1: Entry 63 always reads as zero on every read port, and writes to index 63 leave no trace.
- R2: The narrow read port returns bits 31:0 of the selected entry in bits 31:0 and zero in bits 63:32.
- R3: An indexed write with `wr_narrow` high stores `wr_data[31:0]` sign-extended to 64 bits. With `wr_narrow` low it stores all 64 bits of `wr_data`.
- R4: The base pointer lives in entry 16, the return address in entry 18 and the vector base in entry 20. Each alias reads bits 31:0 of its entry. An alias write stores its 32-bit value sign-extended to 64 bits.
- R5: Entry 17 holds the accumulator. `acc_lo` is bits 31:0 and `acc_hi` is bits 63:32. A write to one half leaves the other half unchanged, and both halves may be written in the same cycle.
- R6: The condition flag is bit 0 of entry 19. A flag write changes only bit 0 and keeps bits 63:1.
- R7: Both full read ports show the entry's value before the clock edge. A write becomes visible after the rising edge that accepts it.
- R8: When an indexed write and an alias write hit the same entry in one cycle, the alias value wins in the bits the alias owns. The indexed value lands in all the other bits.
- R9: While `rst` is high at a rising edge, every entry is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx_a | input | 6 | Index for full read port A |
| rd_data_a | output | 64 | Entry value for port A |
| rd_idx_b | input | 6 | Index for full read port B |
| rd_data_b | output | 64 | Entry value for port B |
| rd_narrow_idx | input | 6 | Index for the 32-bit view |
| rd_narrow_data | output | 64 | Low word of the entry, zero-extended |
| wr_en | input | 1 | Indexed write enable |
| wr_idx | input | 6 | Indexed write target |
| wr_narrow | input | 1 | 1: sign-extend bits 31:0 when writing |
| wr_data | input | 64 | Indexed write value |
| base_ptr_we | input | 1 | Base pointer write enable |
| base_ptr_d | input | 32 | Base pointer write value |
| base_ptr_q | output | 32 | Base pointer (entry 16, low word) |
| ret_addr_we | input | 1 | Return address write enable |
| ret_addr_d | input | 32 | Return address write value |
| ret_addr_q | output | 32 | Return address (entry 18, low word) |
| vec_base_we | input | 1 | Vector base write enable |
| vec_base_d | input | 32 | Vector base write value |
| vec_base_q | output | 32 | Vector base (entry 20, low word) |
| acc_lo_we | input | 1 | Accumulator low half write enable |
| acc_lo_d | input | 32 | Accumulator low half write value |
| acc_lo_q | output | 32 | Entry 17 bits 31:0 |
| acc_hi_we | input | 1 | Accumulator high half write enable |
| acc_hi_d | input | 32 | Accumulator high half write value |
| acc_hi_q | output | 32 | Entry 17 bits 63:32 |
| cond_we | input | 1 | Condition flag write enable |
| cond_d | input | 1 | Condition flag write value |
| cond_q | output | 1 | Entry 19 bit 0 |

## Verification
The assertions assume that no input is X or Z after reset. They also assume that any mix of indexed and alias enables may be active in a cycle, including several alias writes together with an indexed write to the same entry. The properties that look one cycle back name the exact collision case they cover: for example, a lone low-half accumulator write with no indexed write to entry 17. They also exclude the first cycle after reset.

The stimulus holds reset for several cycles and drives every input only at the falling clock edge. Its random phase biases indices toward entries 16 to 20 and 63 so that the collision rules are exercised often.

// File: rtl/gpr_alias_pkg.sv
`timescale 1ns/1ps
package gpr_alias_pkg;
    // Fixed homes of the alias views inside the file
    localparam int IDX_BASE_PTR = 16;
    localparam int IDX_ACC      = 17;
    localparam int IDX_RET_ADDR = 18;
    localparam int IDX_FLAG     = 19;
    localparam int IDX_VEC_BASE = 20;
endpackage

// File: rtl/gpr_alias_overlay.sv
`timescale 1ns/1ps
// Builds, per entry, the bit mask and value that alias writes force this cycle.
module gpr_alias_overlay
    import gpr_alias_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 64
) (
    input  logic                       base_ptr_we,
    input  logic [XLEN/2-1:0]          base_ptr_d,
    input  logic                       ret_addr_we,
    input  logic [XLEN/2-1:0]          ret_addr_d,
    input  logic                       vec_base_we,
    input  logic [XLEN/2-1:0]          vec_base_d,
    input  logic                       acc_lo_we,
    input  logic [XLEN/2-1:0]          acc_lo_d,
    input  logic                       acc_hi_we,
    input  logic [XLEN/2-1:0]          acc_hi_d,
    input  logic                       cond_we,
    input  logic                       cond_d,
    output logic [NREG-1:0][XLEN-1:0]  ov_mask,
    output logic [NREG-1:0][XLEN-1:0]  ov_val
);
    localparam int HALF = XLEN / 2;

    function automatic logic [XLEN-1:0] widen(input logic [HALF-1:0] w);
        return {{HALF{w[HALF-1]}}, w};
    endfunction

    always_comb begin
        ov_mask = '0;
        ov_val  = '0;
        if (base_ptr_we) begin
            ov_mask[IDX_BASE_PTR] = '1;
            ov_val[IDX_BASE_PTR]  = widen(base_ptr_d);
        end
        if (ret_addr_we) begin
            ov_mask[IDX_RET_ADDR] = '1;
            ov_val[IDX_RET_ADDR]  = widen(ret_addr_d);
        end
        if (vec_base_we) begin
            ov_mask[IDX_VEC_BASE] = '1;
            ov_val[IDX_VEC_BASE]  = widen(vec_base_d);
        end
        if (acc_lo_we) begin
            ov_mask[IDX_ACC][HALF-1:0] = '1;
            ov_val[IDX_ACC][HALF-1:0]  = acc_lo_d;
        end
        if (acc_hi_we) begin
            ov_mask[IDX_ACC][XLEN-1:HALF] = '1;
            ov_val[IDX_ACC][XLEN-1:HALF]  = acc_hi_d;
        end
        if (cond_we) begin
            ov_mask[IDX_FLAG][0] = 1'b1;
            ov_val[IDX_FLAG][0]  = cond_d;
        end
    end
endmodule

// File: rtl/gpr_cell.sv
`timescale 1ns/1ps
// One storage row: indexed write first, alias overlay on top.
module gpr_cell #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_hit,
    input  logic [XLEN-1:0] wr_val,
    input  logic [XLEN-1:0] ov_mask,
    input  logic [XLEN-1:0] ov_val,
    output logic [XLEN-1:0] q
);
    logic [XLEN-1:0] base_v;
    logic [XLEN-1:0] next_v;

    always_comb begin
        base_v = wr_hit ? wr_val : q;
        next_v = (base_v & ~ov_mask) | (ov_val & ov_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= next_v;
    end
endmodule

// File: rtl/gpr_read_mux.sv
`timescale 1ns/1ps
// Index-selected read; the top entry reads zero. NARROW picks the 32-bit view.
module gpr_read_mux #(
    parameter int XLEN   = 64,
    parameter int NREG   = 64,
    parameter int IDX_W  = 6,
    parameter bit NARROW = 1'b0
) (
    input  logic [NREG-1:0][XLEN-1:0] rows,
    input  logic [IDX_W-1:0]          idx,
    output logic [XLEN-1:0]           data
);
    localparam int HALF = XLEN / 2;
    localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(NREG - 1);

    generate
        if (NARROW) begin : g_narrow
            always_comb begin
                if (idx == ZERO_IDX) data = '0;
                else                 data = {{HALF{1'b0}}, rows[idx][HALF-1:0]};
            end
        end else begin : g_full
            always_comb begin
                if (idx == ZERO_IDX) data = '0;
                else                 data = rows[idx];
            end
        end
    endgenerate
endmodule

// File: rtl/gpr_alias_file.sv
`timescale 1ns/1ps
module gpr_alias_file
    import gpr_alias_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREG)-1:0]  rd_idx_a,
    output logic [XLEN-1:0]          rd_data_a,
    input  logic [$clog2(NREG)-1:0]  rd_idx_b,
    output logic [XLEN-1:0]          rd_data_b,
    input  logic [$clog2(NREG)-1:0]  rd_narrow_idx,
    output logic [XLEN-1:0]          rd_narrow_data,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic                     wr_narrow,
    input  logic [XLEN-1:0]          wr_data,
    input  logic                     base_ptr_we,
    input  logic [XLEN/2-1:0]        base_ptr_d,
    output logic [XLEN/2-1:0]        base_ptr_q,
    input  logic                     ret_addr_we,
    input  logic [XLEN/2-1:0]        ret_addr_d,
    output logic [XLEN/2-1:0]        ret_addr_q,
    input  logic                     vec_base_we,
    input  logic [XLEN/2-1:0]        vec_base_d,
    output logic [XLEN/2-1:0]        vec_base_q,
    input  logic                     acc_lo_we,
    input  logic [XLEN/2-1:0]        acc_lo_d,
    output logic [XLEN/2-1:0]        acc_lo_q,
    input  logic                     acc_hi_we,
    input  logic [XLEN/2-1:0]        acc_hi_d,
    output logic [XLEN/2-1:0]        acc_hi_q,
    input  logic                     cond_we,
    input  logic                     cond_d,
    output logic                     cond_q
);
    localparam int IDX_W = $clog2(NREG);
    localparam int HALF  = XLEN / 2;
    localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(NREG - 1);
    localparam logic [IDX_W-1:0] ACC_IDX  = IDX_W'(IDX_ACC);
    localparam logic [IDX_W-1:0] FLAG_IDX = IDX_W'(IDX_FLAG);

    logic [NREG-1:0][XLEN-1:0] rows;
    logic [NREG-1:0][XLEN-1:0] ov_mask;
    logic [NREG-1:0][XLEN-1:0] ov_val;
    logic [XLEN-1:0]           wr_val;

    assign wr_val = wr_narrow ? {{HALF{wr_data[HALF-1]}}, wr_data[HALF-1:0]} : wr_data;

    gpr_alias_overlay #(.XLEN(XLEN), .NREG(NREG)) u_overlay (
        .base_ptr_we (base_ptr_we), .base_ptr_d (base_ptr_d),
        .ret_addr_we (ret_addr_we), .ret_addr_d (ret_addr_d),
        .vec_base_we (vec_base_we), .vec_base_d (vec_base_d),
        .acc_lo_we   (acc_lo_we),   .acc_lo_d   (acc_lo_d),
        .acc_hi_we   (acc_hi_we),   .acc_hi_d   (acc_hi_d),
        .cond_we     (cond_we),     .cond_d     (cond_d),
        .ov_mask     (ov_mask),     .ov_val     (ov_val)
    );

    generate
        for (genvar gi = 0; gi < NREG; gi++) begin : g_row
            logic hit;
            assign hit = wr_en && (wr_idx == IDX_W'(gi)) && (IDX_W'(gi) != ZERO_IDX);
            gpr_cell #(.XLEN(XLEN)) u_cell (
                .clk     (clk),
                .rst     (rst),
                .wr_hit  (hit),
                .wr_val  (wr_val),
                .ov_mask (ov_mask[gi]),
                .ov_val  (ov_val[gi]),
                .q       (rows[gi])
            );
        end
    endgenerate

    gpr_read_mux #(.XLEN(XLEN), .NREG(NREG), .IDX_W(IDX_W), .NARROW(1'b0)) u_rd_a (
        .rows (rows), .idx (rd_idx_a), .data (rd_data_a)
    );
    gpr_read_mux #(.XLEN(XLEN), .NREG(NREG), .IDX_W(IDX_W), .NARROW(1'b0)) u_rd_b (
        .rows (rows), .idx (rd_idx_b), .data (rd_data_b)
    );
    gpr_read_mux #(.XLEN(XLEN), .NREG(NREG), .IDX_W(IDX_W), .NARROW(1'b1)) u_rd_n (
        .rows (rows), .idx (rd_narrow_idx), .data (rd_narrow_data)
    );

    assign base_ptr_q = rows[IDX_BASE_PTR][HALF-1:0];
    assign ret_addr_q = rows[IDX_RET_ADDR][HALF-1:0];
    assign vec_base_q = rows[IDX_VEC_BASE][HALF-1:0];
    assign acc_lo_q   = rows[IDX_ACC][HALF-1:0];
    assign acc_hi_q   = rows[IDX_ACC][XLEN-1:HALF];
    assign cond_q     = rows[IDX_FLAG][0];

    AST_ZERO_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && wr_idx == ZERO_IDX) && rd_idx_b == ZERO_IDX) |-> (rd_data_b == '0)); // R1
    AST_NARROW_MATCHES_FULL: assert property (@(posedge clk) disable iff (rst)
        (rd_narrow_idx == rd_idx_a) |-> (rd_narrow_data == {{HALF{1'b0}}, rd_data_a[HALF-1:0]})); // R2
    AST_BASE_PTR_STORE: assert property (@(posedge clk) disable iff (rst)
        base_ptr_we |=> (base_ptr_q == $past(base_ptr_d))); // R4
    AST_ACC_HI_KEPT: assert property (@(posedge clk) disable iff (rst)
        (acc_lo_we && !acc_hi_we && !(wr_en && wr_idx == ACC_IDX)) |=> (acc_hi_q == $past(acc_hi_q))); // R5
    AST_FLAG_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rd_idx_a == FLAG_IDX && $past(rd_idx_a == FLAG_IDX) && $past(cond_we)
         && !$past(wr_en && wr_idx == FLAG_IDX))
        |-> (rd_data_a[XLEN-1:1] == $past(rd_data_a[XLEN-1:1]))); // R6
    AST_ALIAS_OVER_INDEXED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == ACC_IDX && !wr_narrow && acc_lo_we && !acc_hi_we)
        |=> (acc_lo_q == $past(acc_lo_d) && acc_hi_q == $past(wr_data[XLEN-1:HALF]))); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data_a == '0 && rd_data_b == '0 && cond_q == 1'b0)); // R9
endmodule

// File: tb/gpr_alias_file_bench.sv
`timescale 1ns/1ps
module gpr_alias_file_bench;
    logic clk = 1'b0;
    logic rst;
    logic [5:0]  rd_idx_a, rd_idx_b, rd_narrow_idx, wr_idx;
    logic [63:0] rd_data_a, rd_data_b, rd_narrow_data, wr_data;
    logic        wr_en, wr_narrow;
    logic        base_ptr_we, ret_addr_we, vec_base_we, acc_lo_we, acc_hi_we, cond_we, cond_d, cond_q;
    logic [31:0] base_ptr_d, ret_addr_d, vec_base_d, acc_lo_d, acc_hi_d;
    logic [31:0] base_ptr_q, ret_addr_q, vec_base_q, acc_lo_q, acc_hi_q;

    int errors = 0;
    int checks = 0;
    logic [63:0] mdl [0:63];

    always #10 clk = ~clk;

    gpr_alias_file u_gpr_alias_file (
        .clk(clk), .rst(rst),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .rd_narrow_idx(rd_narrow_idx), .rd_narrow_data(rd_narrow_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_narrow(wr_narrow), .wr_data(wr_data),
        .base_ptr_we(base_ptr_we), .base_ptr_d(base_ptr_d), .base_ptr_q(base_ptr_q),
        .ret_addr_we(ret_addr_we), .ret_addr_d(ret_addr_d), .ret_addr_q(ret_addr_q),
        .vec_base_we(vec_base_we), .vec_base_d(vec_base_d), .vec_base_q(vec_base_q),
        .acc_lo_we(acc_lo_we), .acc_lo_d(acc_lo_d), .acc_lo_q(acc_lo_q),
        .acc_hi_we(acc_hi_we), .acc_hi_d(acc_hi_d), .acc_hi_q(acc_hi_q),
        .cond_we(cond_we), .cond_d(cond_d), .cond_q(cond_q)
    );

    function automatic logic [63:0] sx(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [63:0] peek(input logic [5:0] i);
        return (i == 6'd63) ? 64'd0 : mdl[i];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_narrow = 0; wr_idx = 0; wr_data = 0;
        base_ptr_we = 0; ret_addr_we = 0; vec_base_we = 0;
        acc_lo_we = 0; acc_hi_we = 0; cond_we = 0;
        base_ptr_d = 0; ret_addr_d = 0; vec_base_d = 0; acc_lo_d = 0; acc_hi_d = 0; cond_d = 0;
    endtask

    // Compare every output against the model, then advance one clock.
    // Called just after a falling edge; returns just after the next one.
    task automatic step();
        logic [63:0] nxt [0:63];
        #2;
        chk("R7 port A", rd_data_a, peek(rd_idx_a));
        chk("R7 port B", rd_data_b, peek(rd_idx_b));
        chk("R2 narrow view", rd_narrow_data, {32'd0, peek(rd_narrow_idx)[31:0]});
        chk("R4 base ptr", {32'd0, base_ptr_q}, {32'd0, mdl[16][31:0]});
        chk("R4 ret addr", {32'd0, ret_addr_q}, {32'd0, mdl[18][31:0]});
        chk("R4 vec base", {32'd0, vec_base_q}, {32'd0, mdl[20][31:0]});
        chk("R5 acc lo", {32'd0, acc_lo_q}, {32'd0, mdl[17][31:0]});
        chk("R5 acc hi", {32'd0, acc_hi_q}, {32'd0, mdl[17][63:32]});
        chk("R6 cond", {63'd0, cond_q}, {63'd0, mdl[19][0]});
        nxt = mdl;
        if (wr_en && wr_idx != 6'd63) nxt[wr_idx] = wr_narrow ? sx(wr_data[31:0]) : wr_data;
        if (base_ptr_we) nxt[16] = sx(base_ptr_d);
        if (ret_addr_we) nxt[18] = sx(ret_addr_d);
        if (vec_base_we) nxt[20] = sx(vec_base_d);
        if (acc_lo_we) nxt[17][31:0] = acc_lo_d;
        if (acc_hi_we) nxt[17][63:32] = acc_hi_d;
        if (cond_we) nxt[19][0] = cond_d;
        @(posedge clk);
        mdl = nxt;
        @(negedge clk);
        idle();
    endtask

    task automatic look(input string tag, input logic [5:0] i, input logic [63:0] exp);
        rd_idx_a = i;
        #1;
        chk(tag, rd_data_a, exp);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; idle();
        rd_idx_a = 0; rd_idx_b = 0; rd_narrow_idx = 0;
        for (int i = 0; i < 64; i++) mdl[i] = 64'd0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R9: every entry reads zero after reset
        for (int i = 0; i < 64; i++) look("R9 reset clear", 6'(i), 64'd0);

        // R1: write to the zero entry is discarded
        wr_en = 1; wr_idx = 63; wr_data = '1; step();
        look("R1 zero entry", 63, 64'd0);
        rd_narrow_idx = 63; rd_idx_b = 63; #1;
        chk("R1 zero entry port B", rd_data_b, 64'd0);
        chk("R1 zero entry narrow", rd_narrow_data, 64'd0);

        // R7: same-cycle read sees old value, new value after the edge
        wr_en = 1; wr_idx = 7; wr_data = 64'hCAFE_0000_1234_5678; rd_idx_a = 7; #1;
        chk("R7 old value before edge", rd_data_a, 64'd0);
        step();
        look("R7 new value after edge", 7, 64'hCAFE_0000_1234_5678);

        // R3: narrow indexed write sign-extends, upper input bits ignored
        wr_en = 1; wr_idx = 5; wr_narrow = 1; wr_data = 64'h1357_9BDF_8000_1234; step();
        look("R3 narrow write negative", 5, 64'hFFFF_FFFF_8000_1234);
        wr_en = 1; wr_idx = 6; wr_narrow = 1; wr_data = 64'hFFFF_0000_7000_0001; step();
        look("R3 narrow write positive", 6, 64'h0000_0000_7000_0001);
        rd_narrow_idx = 5; #1;
        chk("R2 narrow read zero-extends", rd_narrow_data, 64'h0000_0000_8000_1234);

        // R4: 32-bit aliases
        base_ptr_we = 1; base_ptr_d = 32'h9000_0001; step();
        look("R4 base ptr entry 16", 16, 64'hFFFF_FFFF_9000_0001);
        chk("R4 base ptr read", {32'd0, base_ptr_q}, 64'h9000_0001);
        ret_addr_we = 1; ret_addr_d = 32'h0000_4444; vec_base_we = 1; vec_base_d = 32'hA000_0000; step();
        look("R4 ret addr entry 18", 18, 64'h0000_0000_0000_4444);
        look("R4 vec base entry 20", 20, 64'hFFFF_FFFF_A000_0000);

        // R5: accumulator halves merge
        wr_en = 1; wr_idx = 17; wr_data = 64'h0123_4567_89AB_CDEF; step();
        acc_lo_we = 1; acc_lo_d = 32'hDEAD_BEEF; step();
        look("R5 lo write keeps hi", 17, 64'h0123_4567_DEAD_BEEF);
        acc_hi_we = 1; acc_hi_d = 32'h0BAD_F00D; step();
        look("R5 hi write keeps lo", 17, 64'h0BAD_F00D_DEAD_BEEF);
        acc_hi_we = 1; acc_hi_d = 32'h1111_2222; acc_lo_we = 1; acc_lo_d = 32'h3333_4444; step();
        look("R5 both halves", 17, 64'h1111_2222_3333_4444);

        // R6: condition flag is bit 0 of entry 19
        wr_en = 1; wr_idx = 19; wr_data = 64'hFFFF_FFFF_FFFF_FFFE; step();
        cond_we = 1; cond_d = 1; step();
        look("R6 flag set keeps upper", 19, 64'hFFFF_FFFF_FFFF_FFFF);
        cond_we = 1; cond_d = 0; step();
        look("R6 flag clear keeps upper", 19, 64'hFFFF_FFFF_FFFF_FFFE);

        // R8: alias wins in its own bits during collisions
        wr_en = 1; wr_idx = 17; wr_data = 64'hAAAA_AAAA_5555_5555; acc_lo_we = 1; acc_lo_d = 32'h1234_5678; step();
        look("R8 acc lo over indexed", 17, 64'hAAAA_AAAA_1234_5678);
        wr_en = 1; wr_idx = 16; wr_data = 64'h7777_7777_7777_7777; base_ptr_we = 1; base_ptr_d = 32'h0000_00FF; step();
        look("R8 base ptr over indexed", 16, 64'h0000_0000_0000_00FF);
        wr_en = 1; wr_idx = 19; wr_data = 64'h8000_0000_0000_0000; cond_we = 1; cond_d = 1; step();
        look("R8 flag over indexed", 19, 64'h8000_0000_0000_0001);

        // Random traffic, biased towards alias entries and the zero entry
        for (int n = 0; n < 4000; n++) begin
            int sel;
            sel = $urandom_range(0, 3);
            wr_en = $urandom_range(0, 1);
            wr_idx = (sel == 0) ? 6'($urandom_range(16, 20)) : (sel == 1) ? 6'd63 : 6'($urandom_range(0, 63));
            wr_narrow = $urandom_range(0, 1);
            wr_data = {$urandom, $urandom};
            base_ptr_we = ($urandom_range(0, 3) == 0); base_ptr_d = $urandom;
            ret_addr_we = ($urandom_range(0, 3) == 0); ret_addr_d = $urandom;
            vec_base_we = ($urandom_range(0, 3) == 0); vec_base_d = $urandom;
            acc_lo_we = ($urandom_range(0, 2) == 0); acc_lo_d = $urandom;
            acc_hi_we = ($urandom_range(0, 2) == 0); acc_hi_d = $urandom;
            cond_we = ($urandom_range(0, 2) == 0); cond_d = 1'($urandom);
            rd_idx_a = (sel == 2) ? 6'($urandom_range(16, 20)) : 6'($urandom_range(0, 63));
            rd_idx_b = $urandom_range(0, 63);
            rd_narrow_idx = (sel == 3) ? 6'd63 : 6'($urandom_range(0, 63));
            step();
        end

        // R9: a later reset clears everything again
        rst = 1; step();
        rst = 0;
        for (int i = 0; i < 64; i++) mdl[i] = 64'd0;
        for (int i = 0; i < 64; i++) look("R9 reset clear again", 6'(i), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule